// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a host bridge and rewrites request addresses through a small bank of programmable windows. Each window is described by a 64-bit match value, a 64-bit mask, a 64-bit remap base and a 32-bit action word. All of these are loaded through a write-only 32-bit register port. For every request the block compares the address against all enabled windows at once. On a hit it returns the translated address and the winning window's action word. On a miss it returns the address untouched and a programmable default action word.

The action word tells the downstream packet builder what kind of transaction to issue and which attributes to attach. The translator carries that word through unchanged and does not interpret it. The block answers one request per cycle. With the default configuration the answer is registered, so it appears one cycle after the request.

Top module: `outbound_window_xlate`

## Requirements
- R1: After reset every window is disabled and the default action word is zero, so every request misses, returns its own address and returns action 0.
- R2: Window w is programmed at byte address 0x4C00 + 0x20*w. The offsets within that block are 0x00 for match bits [31:0], 0x04 for match [63:32], 0x08 for remap [31:0], 0x0C for remap [63:32], 0x10 for mask [31:0], 0x14 for mask [63:32] and 0x18 for the action word. The default action word is at 0x4CFC. A write to any other address changes nothing.
- R3: A window hits when its enable bit (bit 0 of the match [31:0] register) is 1 and (A & M) == (MATCH & M), where A is the request address and M is the mask with bits [15:0] forced to zero. Match bit 0 is therefore never compared.
- R4: On a hit, rsp_addr takes the remap value in the bit positions where M is 1 and the request address in the positions where M is 0. rsp_action is the window's action word, passed on verbatim. In that word, bits [3:0] give the type (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message), bit 11 enables attributes, bits [10:8] hold the traffic class, and bits 7, 6, 5 and 4 are relaxed ordering, no-snoop, poison and ID-based ordering.
- R5: When several windows hit, the lowest-numbered one is used, and rsp_win reports its number.
- R6: On a miss, rsp_hit is 0, rsp_win is 0, rsp_addr equals the request address and rsp_action equals the default action word.
- R7: With OUT_REG=1, rsp_valid and the response fields appear exactly one cycle after req_valid, and rsp_valid is 0 in cycles that follow no request.
- R8: A request presented in the same cycle as a register write is translated with the configuration that existed before that write. The write takes effect from the next request.
- R9: Clearing the enable bit of a window makes addresses that it previously matched miss. Setting the bit again restores the hit.
- R10: Mask bits [15:0] have no effect. A mask with those bits set behaves like the same mask with them cleared, so the 16 low address bits always pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RA_W (16) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | ADDR_W (64) | Address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | IDX_W (3) | Number of the matching window, 0 on a miss |
| rsp_addr | output | ADDR_W (64) | Translated or passed-through address |
| rsp_action | output | 32 | Action word of the window, or the default action word |

## Verification
Configuration writes and lookups can land in the same cycle. This can happen when a window's action word is rewritten while traffic through that window is still flowing. The bench provokes it by driving a write to window 0's action register and a request inside window 0 on the same clock edge. It requires the old action word in that response and the new word in the next one. Overlapping windows give a second collision, this time inside the compare stage. An address covered by two enabled windows must resolve to the lower-numbered window, and the bench confirms this by window number, address and action.

// File: rtl/owx_pkg.sv
package owx_pkg;
   localparam int unsigned DATA_W      = 32;
   localparam int unsigned OFS_MATCH_L = 'h00;
   localparam int unsigned OFS_MATCH_H = 'h04;
   localparam int unsigned OFS_REMAP_L = 'h08;
   localparam int unsigned OFS_REMAP_H = 'h0C;
   localparam int unsigned OFS_MASK_L  = 'h10;
   localparam int unsigned OFS_MASK_H  = 'h14;
   localparam int unsigned OFS_ACTION  = 'h18;
   localparam int unsigned OFS_SPAN    = 'h1C;

   typedef enum logic [3:0] {
      XT_MEM  = 4'h0,
      XT_IO   = 4'h4,
      XT_CFG0 = 4'h8,
      XT_CFG1 = 4'h9,
      XT_MSG  = 4'hC
   } xact_type_e;
endpackage

// File: rtl/owx_regfile.sv
module owx_regfile
   import owx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 8,
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned RA_W    = 16,
   parameter int unsigned BASE    = 'h4C00,
   parameter int unsigned STRIDE  = 'h20
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [RA_W-1:0]                    wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]     match_o,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]     remap_o,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]     mask_o,
   output logic [NUM_WIN-1:0][DATA_W-1:0]     action_o,
   output logic [DATA_W-1:0]                  dflt_o
);
   localparam int unsigned HI_W      = ADDR_W - DATA_W;
   localparam int unsigned DFLT_OFS  = BASE + STRIDE*(NUM_WIN-1) + OFS_ACTION + 4;
   localparam int unsigned LAST_BYTE = BASE + STRIDE*NUM_WIN;

   if (ADDR_W <= DATA_W || ADDR_W > 2*DATA_W) begin : g_bad_aw
      $error("owx_regfile: ADDR_W must lie in (32, 64]");
   end
   if (STRIDE < OFS_SPAN + 4) begin : g_bad_stride
      $error("owx_regfile: STRIDE too small for a window block");
   end
   if (LAST_BYTE > (1 << RA_W)) begin : g_bad_ra
      $error("owx_regfile: register map exceeds RA_W");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] match_q, remap_q, mask_q;
   logic [NUM_WIN-1:0][DATA_W-1:0] action_q;
   logic [DATA_W-1:0]              dflt_q;

   function automatic logic [RA_W-1:0] slot(input int unsigned w, input int unsigned o);
      return RA_W'(BASE + STRIDE*w + o);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= '0;
         remap_q  <= '0;
         mask_q   <= '0;
         action_q <= '0;
         dflt_q   <= '0;
      end else if (wr_en) begin
         for (int unsigned w = 0; w < NUM_WIN; w++) begin
            if (wr_addr == slot(w, OFS_MATCH_L)) match_q[w][DATA_W-1:0]      <= wr_data;
            if (wr_addr == slot(w, OFS_MATCH_H)) match_q[w][ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
            if (wr_addr == slot(w, OFS_REMAP_L)) remap_q[w][DATA_W-1:0]      <= wr_data;
            if (wr_addr == slot(w, OFS_REMAP_H)) remap_q[w][ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
            if (wr_addr == slot(w, OFS_MASK_L))  mask_q[w][DATA_W-1:0]       <= wr_data;
            if (wr_addr == slot(w, OFS_MASK_H))  mask_q[w][ADDR_W-1:DATA_W]  <= wr_data[HI_W-1:0];
            if (wr_addr == slot(w, OFS_ACTION))  action_q[w]                 <= wr_data;
         end
         if (wr_addr == RA_W'(DFLT_OFS)) dflt_q <= wr_data;
      end
   end

   assign match_o  = match_q;
   assign remap_o  = remap_q;
   assign mask_o   = mask_q;
   assign action_o = action_q;
   assign dflt_o   = dflt_q;

   // R2: configuration only moves on a write strobe
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(match_q) && $stable(remap_q) && $stable(mask_q)
                  && $stable(action_q) && $stable(dflt_q)));
endmodule

// File: rtl/owx_match.sv
module owx_match #(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_BITS = 16
) (
   input  logic              enable,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] match,
   input  logic [ADDR_W-1:0] mask,
   input  logic [ADDR_W-1:0] remap,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr
);
   localparam logic [ADDR_W-1:0] LOW_M =
      {{(ADDR_W-GRAN_BITS){1'b0}}, {GRAN_BITS{1'b1}}};

   if (GRAN_BITS < 1 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("owx_match: GRAN_BITS out of range");
   end

   logic [ADDR_W-1:0] m_eff;

   always_comb begin
      m_eff = mask & ~LOW_M;
      hit   = enable && ((addr & m_eff) == (match & m_eff));
      xaddr = (remap & m_eff) | (addr & ~m_eff);
   end
endmodule

// File: rtl/owx_pick.sv
module owx_pick
   import owx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 8,
   parameter int unsigned ADDR_W  = 64,
   localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0]             hit_vec,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr,
   input  logic [NUM_WIN-1:0][DATA_W-1:0] action,
   input  logic [DATA_W-1:0]              dflt,
   input  logic [ADDR_W-1:0]              addr,
   output logic                           any_o,
   output logic [IDX_W-1:0]               sel_o,
   output logic [ADDR_W-1:0]              addr_o,
   output logic [DATA_W-1:0]              action_o
);
   always_comb begin
      any_o    = 1'b0;
      sel_o    = '0;
      addr_o   = addr;
      action_o = dflt;
      for (int w = NUM_WIN-1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            any_o    = 1'b1;
            sel_o    = IDX_W'(w);
            addr_o   = xaddr[w];
            action_o = action[w];
         end
      end
   end

   // R5: the chosen window hits and none below it does
   always_comb begin
      if (any_o) begin
         p_pick_lowest_r5: assert (hit_vec[sel_o] &&
            ((hit_vec & ((NUM_WIN'(1) << sel_o) - NUM_WIN'(1))) == '0));
      end
   end
endmodule

// File: rtl/outbound_window_xlate.sv
module outbound_window_xlate
   import owx_pkg::*;
#(
   parameter int unsigned NUM_WIN   = 8,
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_BITS = 16,
   parameter int unsigned RA_W      = 16,
   parameter int unsigned BASE      = 'h4C00,
   parameter int unsigned STRIDE    = 'h20,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_win,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [31:0]       rsp_action
);
   if (NUM_WIN < 2 || NUM_WIN > 16) begin : g_bad_nw
      $error("outbound_window_xlate: NUM_WIN must be 2..16");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] c_match, c_remap, c_mask, w_xaddr;
   logic [NUM_WIN-1:0][DATA_W-1:0] c_action;
   logic [DATA_W-1:0]              c_dflt;
   logic [NUM_WIN-1:0]             win_en, w_hit;
   logic                           p_any;
   logic [IDX_W-1:0]               p_sel;
   logic [ADDR_W-1:0]              p_addr;
   logic [DATA_W-1:0]              p_action;

   owx_regfile #(
      .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .RA_W(RA_W),
      .BASE(BASE), .STRIDE(STRIDE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .match_o(c_match), .remap_o(c_remap), .mask_o(c_mask),
      .action_o(c_action), .dflt_o(c_dflt)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      assign win_en[w] = c_match[w][0];
      owx_match #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_match (
         .enable(win_en[w]), .addr(req_addr),
         .match(c_match[w]), .mask(c_mask[w]), .remap(c_remap[w]),
         .hit(w_hit[w]), .xaddr(w_xaddr[w])
      );
   end

   owx_pick #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_pick (
      .hit_vec(w_hit), .xaddr(w_xaddr), .action(c_action),
      .dflt(c_dflt), .addr(req_addr),
      .any_o(p_any), .sel_o(p_sel), .addr_o(p_addr), .action_o(p_action)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_win    <= '0;
            rsp_addr   <= '0;
            rsp_action <= '0;
         end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && p_any;
            rsp_win    <= p_sel;
            rsp_addr   <= p_addr;
            rsp_action <= p_action;
         end
      end

      // R7: one response for each request, one cycle later
      p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);
      p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid);
      // R6: a miss returns the request address and the default action
      p_miss_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr) &&
            rsp_action == $past(c_dflt) && rsp_win == '0));
      // R3: a reported window was enabled when the request arrived
      p_hit_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rsp_hit) |-> (|($past(win_en) & (NUM_WIN'(1) << rsp_win))));
   end else begin : g_comb
      assign rsp_valid  = req_valid;
      assign rsp_hit    = req_valid && p_any;
      assign rsp_win    = p_sel;
      assign rsp_addr   = p_addr;
      assign rsp_action = p_action;
   end
endmodule

// File: tb/outbound_window_xlate_bench.sv
module outbound_window_xlate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [2:0]  rsp_win;
   logic [63:0] rsp_addr;
   logic [31:0] rsp_action;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   logic [63:0] m_match [NW];
   logic [63:0] m_remap [NW];
   logic [63:0] m_mask  [NW];
   logic [31:0] m_act   [NW];
   logic [31:0] m_dflt;

   outbound_window_xlate u_outbound_window_xlate (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
      .rsp_addr(rsp_addr), .rsp_action(rsp_action)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [15:0] ra(input int w, input int o);
      return 16'(16'h4C00 + 32*w + o);
   endfunction

   // R2 map applied to the bench's own copy of the configuration
   task automatic model_write(input logic [15:0] a, input logic [31:0] d);
      if (a == 16'h4CFC) m_dflt = d;
      for (int w = 0; w < NW; w++) begin
         if (a == ra(w, 'h00)) m_match[w][31:0]  = d;
         if (a == ra(w, 'h04)) m_match[w][63:32] = d;
         if (a == ra(w, 'h08)) m_remap[w][31:0]  = d;
         if (a == ra(w, 'h0C)) m_remap[w][63:32] = d;
         if (a == ra(w, 'h10)) m_mask[w][31:0]   = d;
         if (a == ra(w, 'h14)) m_mask[w][63:32]  = d;
         if (a == ra(w, 'h18)) m_act[w]          = d;
      end
   endtask

   // R3, R4, R5, R6 expected result
   task automatic expect_of(input logic [63:0] a, output logic hit, output logic [2:0] win,
                            output logic [63:0] xa, output logic [31:0] act);
      hit = 0; win = 0; xa = a; act = m_dflt;
      for (int w = 0; w < NW; w++) begin
         logic [63:0] m;
         m = m_mask[w] & 64'hFFFF_FFFF_FFFF_0000;
         if (!hit && m_match[w][0] && ((a & m) == (m_match[w] & m))) begin
            hit = 1; win = 3'(w);
            xa  = (m_remap[w] & m) | (a & ~m);
            act = m_act[w];
         end
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act_v, input logic [63:0] exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act_v, exp_v);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 0;
      model_write(a, d);
   endtask

   task automatic program_win(input int w, input logic [63:0] mt, input logic [63:0] mk,
                              input logic [63:0] rm, input logic [31:0] ac);
      wr(ra(w, 'h04), mt[63:32]);
      wr(ra(w, 'h08), rm[31:0]);
      wr(ra(w, 'h0C), rm[63:32]);
      wr(ra(w, 'h10), mk[31:0]);
      wr(ra(w, 'h14), mk[63:32]);
      wr(ra(w, 'h18), ac);
      wr(ra(w, 'h00), mt[31:0]);
   endtask

   task automatic lookup(input logic [63:0] a, input string req);
      logic eh; logic [2:0] ew; logic [63:0] ea; logic [31:0] ec;
      expect_of(a, eh, ew, ea, ec);
      @(negedge clk);
      req_valid = 1; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      check(rsp_valid == 1, req, "valid", 64'(rsp_valid), 64'd1);
      check(rsp_hit == eh, req, "hit", 64'(rsp_hit), 64'(eh));
      check(rsp_win == ew, req, "win", 64'(rsp_win), 64'(ew));
      check(rsp_addr == ea, req, "addr", rsp_addr, ea);
      check(rsp_action == ec, req, "action", 64'(rsp_action), 64'(ec));
   endtask

   task automatic t_reset;
      check(rsp_valid == 0, "R1", "valid after reset", 64'(rsp_valid), 64'd0);
      lookup(64'h0000_0000_8001_2345, "R1");
      lookup(64'hFFFF_0000_0000_0000, "R1");
      check(rsp_action == 0 && rsp_addr == 64'hFFFF_0000_0000_0000,
            "R1", "reset miss", rsp_addr, 64'hFFFF_0000_0000_0000);
   endtask

   task automatic t_basic;
      wr(16'h4CFC, 32'h0000_09A0);
      program_win(0, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFF0_0000,
                  64'h0000_0012_3450_0000, 32'h0000_0004);
      lookup(64'h0000_0000_8001_2345, "R4");
      check(rsp_addr == 64'h0000_0012_3451_2345, "R4", "remap value",
            rsp_addr, 64'h0000_0012_3451_2345);
      check(rsp_action[3:0] == 4'h4, "R4", "io type", 64'(rsp_action[3:0]), 64'h4);
      lookup(64'h0000_0000_8010_0000, "R6");
      check(rsp_action == 32'h0000_09A0, "R2", "default at 0x4CFC",
            64'(rsp_action), 64'h9A0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      req_valid = 1; req_addr = 64'h0000_0000_8000_0010;
      @(negedge clk);
      req_valid = 0;
      check(rsp_valid == 1, "R7", "response after one cycle", 64'(rsp_valid), 64'd1);
      @(negedge clk);
      check(rsp_valid == 0, "R7", "no response without request", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_priority;
      program_win(5, 64'h0000_0001_2000_0001, 64'hFFFF_FFFF_F000_0000,
                  64'h0000_000B_0000_0000, 32'h0000_0008);
      program_win(2, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_0000_0000,
                  64'h0000_000A_0000_0000, 32'h0000_0009);
      lookup(64'h0000_0001_2345_6789, "R5");
      check(rsp_win == 3'd2, "R5", "lowest window", 64'(rsp_win), 64'd2);
      lookup(64'h0000_0001_0000_0010, "R5");
      wr(ra(2, 'h00), 32'h0000_0000);
      lookup(64'h0000_0001_2345_6789, "R5");
      check(rsp_win == 3'd5, "R5", "next window", 64'(rsp_win), 64'd5);
   endtask

   task automatic t_mask_low;
      program_win(3, 64'h0000_0004_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF,
                  64'h0000_0007_7777_0000, 32'h0000_000C);
      lookup(64'h0000_0004_0000_ABCD, "R10");
      check(rsp_addr == 64'h0000_0007_7777_ABCD, "R10", "low bits pass",
            rsp_addr, 64'h0000_0007_7777_ABCD);
   endtask

   task automatic t_enable;
      program_win(6, 64'h0000_0006_0000_0000, 64'hFFFF_FFFF_FFFF_0000,
                  64'h0000_0009_0000_0000, 32'h0000_0ED0);
      lookup(64'h0000_0006_0000_0042, "R9");
      check(rsp_hit == 0, "R9", "disabled window misses", 64'(rsp_hit), 64'd0);
      wr(ra(6, 'h00), 32'h0000_0001);
      lookup(64'h0000_0006_0000_0042, "R3");
      check(rsp_hit == 1, "R3", "enabled window hits", 64'(rsp_hit), 64'd1);
      wr(ra(6, 'h00), 32'h0000_0000);
      lookup(64'h0000_0006_0000_0042, "R9");
   endtask

   task automatic t_bad_addr;
      wr(16'h4C1C, 32'hFFFF_FFFF);
      wr(16'h4C02, 32'hFFFF_FFFF);
      wr(16'h4D00, 32'hFFFF_FFFF);
      wr(16'h0C00, 32'hFFFF_FFFF);
      lookup(64'h0000_0000_8001_2345, "R2");
      check(rsp_action == 32'h4, "R2", "stray writes ignored", 64'(rsp_action), 64'h4);
      lookup(64'h0000_00FF_0000_0000, "R2");
   endtask

   task automatic t_same_cycle;
      logic eh; logic [2:0] ew; logic [63:0] ea; logic [31:0] ec;
      expect_of(64'h0000_0000_8000_0100, eh, ew, ea, ec);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = ra(0, 'h18); reg_wdata = 32'h0000_0000;
      req_valid = 1; req_addr = 64'h0000_0000_8000_0100;
      @(negedge clk);
      reg_wr_en = 0; req_valid = 0;
      model_write(ra(0, 'h18), 32'h0000_0000);
      check(rsp_action == ec, "R8", "old action in collision", 64'(rsp_action), 64'(ec));
      check(rsp_hit == 1 && rsp_win == 0, "R8", "collision hit", 64'(rsp_win), 64'd0);
      lookup(64'h0000_0000_8000_0100, "R8");
      check(rsp_action == 0, "R8", "new action next", 64'(rsp_action), 64'd0);
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         m_match[w] = '0; m_remap[w] = '0; m_mask[w] = '0; m_act[w] = '0;
      end
      m_dflt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_latency;
      t_priority;
      t_mask_low;
      t_enable;
      t_bad_addr;
      t_same_cycle;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule